// File: doc/BRIEF.md
# Converter Polling Sequencer

This block is the host side of a link to a low-rate serial sigma-delta converter. It runs from the system clock and drives the converter's chip-select, serial clock and serial data-in lines. A start pulse makes it write the filter byte and the mode byte. It then waits for the converter to signal that a result is ready, clocks in a 24-bit result and presents it as a one-cycle valid pulse with data.

Three acquisition styles are available. Single-shot takes one result and releases the bus. Repeated polling sends a read command for every result until asked to stop. Streaming enters the converter's continuous-read state once, then only clocks result bits. A ready indication is the converter pulling its data line low while it is selected. The sequencer watches for that falling edge and flags a timeout if no edge arrives in time. On request it can also send a long run of ones that brings a lost converter interface back to its default state.

Top module: `conv_poller`

## Requirements
- R1: After reset `csN` and `sclk` are high, `mosi` is low, and `busy` and `resultValid` are low.
- R2: A `startPulse` in idle sends four bytes under one chip-select: 0x20, then `filterCfg`, then 0x10, then a mode byte. The mode byte has bits 5..0 from `modeCfg`. Its bits 7..6 are 10 when `opMode` is 0 (single) and 00 for 1 (repeated) or 2 (streaming).
- R3: `sclk` idles high. Each serial bit holds `sclk` low for exactly HALF_DIV system clocks (default 11, i.e. 110 ns at 100 MHz) and then high. `mosi` changes only when `sclk` falls, `miso` is taken when `sclk` rises, and bytes go MSB first. `sclk` is never low while `csN` is high.
- R4: Ready is a falling edge of `miso` seen while `csN` is low and the sequencer is waiting. In single and repeated modes it then sends 0x38 and clocks 24 bits. The result appears MSB first on `resultData` with a one-cycle `resultValid` pulse.
- R5: In single mode, `csN` returns high and `busy` drops after the one result.
- R6: In repeated mode the 0x38-plus-24-bit read repeats for every ready edge. A `stopReq` returns the block to idle from the wait, and no further bytes are sent.
- R7: In streaming mode the byte 0x3C follows the configuration once. After that, each ready edge is followed by 24 clocks with `mosi` held low and no command byte.
- R8: After a `stopReq` in streaming mode, the next ready edge is answered with 0x38 instead of a read. No result is produced and the block returns to idle.
- R9: If no ready edge arrives within `timeoutLimit` cycles of waiting, `timeoutErr` pulses for one cycle, `csN` is released and the block goes idle.
- R10: A `resyncReq` in idle sends RESYNC_BITS (32) clocks with `mosi` high under one chip-select. `busy` then stays high with `csN` high for SETTLE_CYC cycles before the block accepts new work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin configuration and acquisition (idle only) |
| opMode | input | 2 | 0 single, 1 repeated, 2 streaming, 3 as repeated |
| stopReq | input | 1 | End repeated or streaming acquisition |
| resyncReq | input | 1 | Send the interface-recovery run of ones (idle only) |
| filterCfg | input | 8 | Byte written to the converter's rate register |
| modeCfg | input | 8 | Mode byte; bits 7..6 replaced per opMode |
| timeoutLimit | input | TO_W | Cycles allowed for a ready edge |
| miso | input | 1 | Converter data-out / ready line |
| csN | output | 1 | Active-low converter select |
| sclk | output | 1 | Serial clock, idle high |
| mosi | output | 1 | Serial data to converter |
| resultValid | output | 1 | One-cycle strobe for resultData |
| resultData | output | DATA_W | Last result read |
| timeoutErr | output | 1 | One-cycle strobe on ready timeout |
| busy | output | 1 | High whenever not idle |

## Verification
The assertions assume several things about the inputs. `miso` only changes after a falling `sclk` edge or while the bus is quiet. The converter holds `miso` high until a result is ready and pulls it low once per result. The start, stop and resync requests are single-cycle pulses from the system clock domain. The bench's converter model keeps to these rules: it shifts its word out on falling `sclk` edges, raises the ready line again after each result is taken, and drives high whenever it is deselected. Requests are driven on the falling system clock edge, away from the design's sampling edge.

// File: rtl/conv_poller_pkg.sv
package conv_poller_pkg;
  localparam logic [1:0] OP_SINGLE = 2'd0;
  localparam logic [1:0] OP_STREAM = 2'd2;

  localparam logic [7:0] CMD_WR_RATE = 8'h20;
  localparam logic [7:0] CMD_WR_MODE = 8'h10;
  localparam logic [7:0] CMD_RD_DATA = 8'h38;
  localparam logic [7:0] CMD_STREAM  = 8'h3C;

  // strobe bundle from control to the serial engine
  typedef struct packed {
    logic       go;
    logic       ones;
    logic [5:0] nBits;
    logic [7:0] txByte;
  } shiftCmd_t;
endpackage

// File: rtl/conv_poller_dp.sv
module conv_poller_dp
  import conv_poller_pkg::*;
#(
  parameter int HALF_DIV = 11,
  parameter int DATA_W   = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftCmd_t         cmd,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [DATA_W-1:0] rxWord,
  output logic              misoFall
);
  localparam int HCW = $clog2(HALF_DIV + 1);
  localparam logic [HCW-1:0] HALF_LAST = HCW'(HALF_DIV - 1);

  logic              active, onesR, sclkR, mosiR, doneR;
  logic [HCW-1:0]    halfCnt;
  logic [5:0]        bitsLeft;
  logic [7:0]        txSh;
  logic [DATA_W-1:0] rxSh;
  logic              misoMeta, misoSync, misoPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0; onesR <= 1'b0; sclkR <= 1'b1; mosiR <= 1'b0; doneR <= 1'b0;
      halfCnt <= '0; bitsLeft <= '0; txSh <= '0; rxSh <= '0;
      misoMeta <= 1'b1; misoSync <= 1'b1; misoPrev <= 1'b1;
    end else begin
      doneR    <= 1'b0;
      misoMeta <= miso;
      misoSync <= misoMeta;
      misoPrev <= misoSync;
      if (!active) begin
        if (cmd.go) begin
          active   <= 1'b1;
          sclkR    <= 1'b0;
          mosiR    <= cmd.ones | cmd.txByte[7];
          txSh     <= {cmd.txByte[6:0], 1'b0};
          onesR    <= cmd.ones;
          bitsLeft <= cmd.nBits;
          halfCnt  <= HALF_LAST;
        end
      end else if (halfCnt != '0) begin
        halfCnt <= halfCnt - 1'b1;
      end else begin
        halfCnt <= HALF_LAST;
        if (!sclkR) begin
          sclkR <= 1'b1;
          rxSh  <= {rxSh[DATA_W-2:0], misoSync};
        end else if (bitsLeft > 6'd1) begin
          sclkR    <= 1'b0;
          mosiR    <= onesR | txSh[7];
          txSh     <= {txSh[6:0], 1'b0};
          bitsLeft <= bitsLeft - 6'd1;
        end else begin
          active <= 1'b0;
          doneR  <= 1'b1;
        end
      end
    end
  end

  assign sclk     = sclkR;
  assign mosi     = mosiR;
  assign done     = doneR;
  assign rxWord   = rxSh;
  assign misoFall = misoPrev & ~misoSync;

  assert_mosi_steady_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sclkR && $past(sclkR)) |-> $stable(mosiR));
  assert_go_only_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.go |-> !active);
endmodule

// File: rtl/conv_poller_ctrl.sv
module conv_poller_ctrl
  import conv_poller_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int TO_W        = 24,
  parameter int RESYNC_BITS = 32,
  parameter int SETTLE_CYC  = 50000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [1:0]        opMode,
  input  logic              stopReq,
  input  logic              resyncReq,
  input  logic [7:0]        filterCfg,
  input  logic [7:0]        modeCfg,
  input  logic [TO_W-1:0]   timeoutLimit,
  input  logic              done,
  input  logic              misoFall,
  input  logic [DATA_W-1:0] rxWord,
  output shiftCmd_t         cmd,
  output logic              csN,
  output logic              resultValid,
  output logic [DATA_W-1:0] resultData,
  output logic              timeoutErr,
  output logic              busy
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CFG, S_STRCMD, S_WAIT, S_RDCMD, S_READ, S_EXIT, S_RESYNC, S_SETTLE
  } state_e;

  state_e          state;
  logic            pending, stopPend, sendState, isStream;
  logic [1:0]      cfgIdx, opLat;
  logic [7:0]      filtLat, modeLat, cfgByte;
  logic [TO_W-1:0] waitCnt;
  logic [SW-1:0]   settleCnt;

  assign isStream  = (opLat == OP_STREAM);
  assign sendState = (state == S_CFG) || (state == S_STRCMD) || (state == S_RDCMD) ||
                     (state == S_READ) || (state == S_EXIT) || (state == S_RESYNC);

  always_comb begin
    case (cfgIdx)
      2'd0:    cfgByte = CMD_WR_RATE;
      2'd1:    cfgByte = filtLat;
      2'd2:    cfgByte = CMD_WR_MODE;
      default: cfgByte = modeLat;
    endcase
  end

  always_comb begin
    cmd = '0;
    cmd.nBits = 6'd8;
    case (state)
      S_CFG:          cmd.txByte = cfgByte;
      S_STRCMD:       cmd.txByte = CMD_STREAM;
      S_RDCMD, S_EXIT: cmd.txByte = CMD_RD_DATA;
      S_READ:         cmd.nBits = 6'(DATA_W);
      S_RESYNC: begin cmd.nBits = 6'(RESYNC_BITS); cmd.ones = 1'b1; end
      default: ;
    endcase
    cmd.go = sendState && !pending;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; pending <= 1'b0; stopPend <= 1'b0; cfgIdx <= '0; opLat <= '0;
      filtLat <= '0; modeLat <= '0; waitCnt <= '0; settleCnt <= '0;
      resultValid <= 1'b0; resultData <= '0; timeoutErr <= 1'b0;
    end else begin
      resultValid <= 1'b0;
      timeoutErr  <= 1'b0;
      if (cmd.go) pending <= 1'b1;
      if (stopReq && state != S_IDLE) stopPend <= 1'b1;
      case (state)
        S_IDLE: begin
          stopPend <= 1'b0;
          if (startPulse) begin
            opLat   <= opMode;
            filtLat <= filterCfg;
            modeLat <= {(opMode == OP_SINGLE) ? 2'b10 : 2'b00, modeCfg[5:0]};
            cfgIdx  <= '0;
            state   <= S_CFG;
          end else if (resyncReq) begin
            state <= S_RESYNC;
          end
        end
        S_CFG: if (done) begin
          pending <= 1'b0;
          if (cfgIdx == 2'd3) begin
            waitCnt <= '0;
            state   <= isStream ? S_STRCMD : S_WAIT;
          end else begin
            cfgIdx <= cfgIdx + 2'd1;
          end
        end
        S_STRCMD: if (done) begin
          pending <= 1'b0; waitCnt <= '0; state <= S_WAIT;
        end
        S_WAIT: begin
          if (stopPend && !isStream)       state <= S_IDLE;
          else if (misoFall)               state <= !isStream ? S_RDCMD : (stopPend ? S_EXIT : S_READ);
          else if (waitCnt == timeoutLimit) begin
            timeoutErr <= 1'b1;
            state      <= S_IDLE;
          end else                         waitCnt <= waitCnt + 1'b1;
        end
        S_RDCMD: if (done) begin pending <= 1'b0; state <= S_READ; end
        S_READ: if (done) begin
          pending     <= 1'b0;
          resultValid <= 1'b1;
          resultData  <= rxWord;
          waitCnt     <= '0;
          state       <= (opLat == OP_SINGLE) ? S_IDLE : S_WAIT;
        end
        S_EXIT: if (done) begin pending <= 1'b0; state <= S_IDLE; end
        S_RESYNC: if (done) begin pending <= 1'b0; settleCnt <= '0; state <= S_SETTLE; end
        S_SETTLE: begin
          if (settleCnt == SETTLE_LAST) state <= S_IDLE;
          else settleCnt <= settleCnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign csN  = (state == S_IDLE) || (state == S_SETTLE);
  assign busy = (state != S_IDLE);

  assert_valid_single_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);
  assert_timeout_releases_R9: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> (csN && !busy));
endmodule

// File: rtl/conv_poller.sv
module conv_poller
  import conv_poller_pkg::*;
#(
  parameter int HALF_DIV    = 11,
  parameter int DATA_W      = 24,
  parameter int TO_W        = 24,
  parameter int RESYNC_BITS = 32,
  parameter int SETTLE_CYC  = 50000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [1:0]        opMode,
  input  logic              stopReq,
  input  logic              resyncReq,
  input  logic [7:0]        filterCfg,
  input  logic [7:0]        modeCfg,
  input  logic [TO_W-1:0]   timeoutLimit,
  input  logic              miso,
  output logic              csN,
  output logic              sclk,
  output logic              mosi,
  output logic              resultValid,
  output logic [DATA_W-1:0] resultData,
  output logic              timeoutErr,
  output logic              busy
);
  shiftCmd_t         cmd;
  logic              done, misoFall;
  logic [DATA_W-1:0] rxWord;

  conv_poller_ctrl #(
    .DATA_W(DATA_W), .TO_W(TO_W), .RESYNC_BITS(RESYNC_BITS), .SETTLE_CYC(SETTLE_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .opMode(opMode), .stopReq(stopReq),
    .resyncReq(resyncReq), .filterCfg(filterCfg), .modeCfg(modeCfg),
    .timeoutLimit(timeoutLimit), .done(done), .misoFall(misoFall), .rxWord(rxWord),
    .cmd(cmd), .csN(csN), .resultValid(resultValid), .resultData(resultData),
    .timeoutErr(timeoutErr), .busy(busy)
  );

  conv_poller_dp #(.HALF_DIV(HALF_DIV), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .miso(miso), .sclk(sclk), .mosi(mosi),
    .done(done), .rxWord(rxWord), .misoFall(misoFall)
  );

  assert_sclk_only_selected_R3: assert property (@(posedge clk) disable iff (!rstN)
    !sclk |-> !csN);
endmodule

// File: tb/conv_poller_bench.sv
module conv_poller_bench;
  localparam int HALF   = 11;
  localparam int SETTLE = 64;

  logic clk = 1'b0, rstN = 1'b0, startPulse = 1'b0, stopReq = 1'b0, resyncReq = 1'b0;
  logic [1:0]  opMode = 2'd0;
  logic [7:0]  filterCfg = 8'h00, modeCfg = 8'h00;
  logic [23:0] timeoutLimit = 24'd100000;
  logic        miso, csN, sclk, mosi, resultValid, timeoutErr, busy;
  logic [23:0] resultData;

  always #5 clk = ~clk;

  conv_poller #(.SETTLE_CYC(SETTLE)) u_conv_poller (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .opMode(opMode), .stopReq(stopReq),
    .resyncReq(resyncReq), .filterCfg(filterCfg), .modeCfg(modeCfg),
    .timeoutLimit(timeoutLimit), .miso(miso), .csN(csN), .sclk(sclk), .mosi(mosi),
    .resultValid(resultValid), .resultData(resultData), .timeoutErr(timeoutErr), .busy(busy)
  );

  // converter model: shifts its word out on falling sclk, high when deselected
  logic        dout = 1'b1;
  logic [31:0] devSh = '1;
  assign miso = csN ? 1'b1 : dout;
  always @(negedge sclk) if (!csN) begin
    dout  = devSh[31];
    devSh = {devSh[30:0], 1'b1};
  end

  // log of bytes the host sends, taken on rising sclk
  logic [7:0] logBytes [0:63];
  int nLog = 0, bitCnt = 0;
  logic [7:0] sh = '0;
  always @(posedge sclk) if (!csN) begin
    sh = {sh[6:0], mosi};
    bitCnt++;
    if (bitCnt == 8) begin
      if (nLog < 64) logBytes[nLog] = sh;
      nLog++;
      bitCnt = 0;
    end
  end
  always @(posedge csN) bitCnt = 0;

  // output monitors, sampled on the falling system clock edge
  logic [23:0] results [0:15];
  int nRes = 0, nTo = 0, cyc = 0, lowRun = 0, lowMin = 1000, lowMax = 0;
  always @(negedge clk) begin
    cyc++;
    if (resultValid) begin
      if (nRes < 16) results[nRes] = resultData;
      nRes++;
    end
    if (timeoutErr) nTo++;
    if (!sclk) lowRun++;
    else if (lowRun != 0) begin
      if (lowRun < lowMin) lowMin = lowRun;
      if (lowRun > lowMax) lowMax = lowRun;
      lowRun = 0;
    end
  end

  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic waitLog(input int n);
    for (int i = 0; i < 40000 && nLog < n; i++) @(negedge clk);
  endtask
  task automatic waitRes(input int n);
    for (int i = 0; i < 40000 && nRes < n; i++) @(negedge clk);
  endtask
  task automatic waitIdle();
    for (int i = 0; i < 40000 && busy; i++) @(negedge clk);
  endtask
  task automatic pulseStart();
    @(negedge clk) startPulse = 1'b1;
    @(negedge clk) startPulse = 1'b0;
  endtask
  task automatic pulseStop();
    @(negedge clk) stopReq = 1'b1;
    @(negedge clk) stopReq = 1'b0;
  endtask
  task automatic readyWord(input logic [23:0] w, input bit stream);
    @(negedge clk);
    devSh = stream ? {w, 8'hFF} : {8'h00, w};
    dout  = 1'b0;
  endtask

  // rate byte, mode byte, converter word; all single-shot acquisitions
  localparam logic [39:0] VEC [4] = '{
    {8'h04, 8'h02, 24'h800000},
    {8'h07, 8'hC6, 24'hFFFFFF},
    {8'h31, 8'h0C, 24'h000000},
    {8'h15, 8'h3F, 24'hA5C3E1}
  };

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(csN && sclk && !mosi, "R1 bus lines idle", {29'b0, csN, sclk, mosi}, 32'h6);
    check(!busy && !resultValid, "R1 busy/valid low", {30'b0, busy, resultValid}, 32'h0);

    // R2 R4 R5 table of single-shot acquisitions
    for (int v = 0; v < 4; v++) begin
      logic [7:0]  fc, mc;
      logic [23:0] w;
      int rBase;
      {fc, mc, w} = VEC[v];
      nLog = 0; rBase = nRes;
      opMode = 2'd0; filterCfg = fc; modeCfg = mc;
      pulseStart();
      waitLog(4);
      check(logBytes[0] == 8'h20, "R2 rate command", logBytes[0], 8'h20);
      check(logBytes[1] == fc,    "R2 rate byte", logBytes[1], fc);
      check(logBytes[2] == 8'h10, "R2 mode command", logBytes[2], 8'h10);
      check(logBytes[3] == {2'b10, mc[5:0]}, "R2 single mode byte", logBytes[3], {2'b10, mc[5:0]});
      repeat (60) @(negedge clk);
      readyWord(w, 1'b0);
      waitRes(rBase + 1);
      dout = 1'b1;
      check(logBytes[4] == 8'h38, "R4 read command", logBytes[4], 8'h38);
      check(results[rBase] == w, "R4 result word", results[rBase], w);
      repeat (5) @(negedge clk);
      check(csN && !busy, "R5 released after one result", {30'b0, csN, busy}, 32'h2);
      check(nLog == 8, "R5 no extra bytes", nLog, 8);
    end
    // R3 low phase width of every bit so far
    check(lowMin == HALF && lowMax == HALF, "R3 sclk low width", {lowMin[15:0], lowMax[15:0]},
          {16'(HALF), 16'(HALF)});

    // R6 repeated mode
    begin
      int rBase;
      nLog = 0; rBase = nRes;
      opMode = 2'd1; filterCfg = 8'h05; modeCfg = 8'hFF;
      pulseStart();
      waitLog(4);
      check(logBytes[3] == 8'h3F, "R2 repeated mode byte", logBytes[3], 8'h3F);
      repeat (60) @(negedge clk);
      readyWord(24'h123456, 1'b0);
      waitRes(rBase + 1); dout = 1'b1;
      repeat (60) @(negedge clk);
      readyWord(24'hFEDCBA, 1'b0);
      waitRes(rBase + 2); dout = 1'b1;
      repeat (30) @(negedge clk);
      pulseStop();
      waitIdle();
      repeat (20) @(negedge clk);
      check(results[rBase] == 24'h123456 && results[rBase+1] == 24'hFEDCBA, "R6 two results",
            results[rBase+1], 24'hFEDCBA);
      check(logBytes[4] == 8'h38 && logBytes[8] == 8'h38, "R6 command per result",
            {logBytes[4], logBytes[8]}, 16'h3838);
      check(nLog == 12 && csN, "R6 stop ends traffic", nLog, 12);
    end

    // R7 R8 streaming
    begin
      int rBase;
      nLog = 0; rBase = nRes;
      opMode = 2'd2; filterCfg = 8'h03; modeCfg = 8'h82;
      pulseStart();
      waitLog(5);
      check(logBytes[3] == 8'h02, "R2 stream mode byte", logBytes[3], 8'h02);
      check(logBytes[4] == 8'h3C, "R7 stream entry byte", logBytes[4], 8'h3C);
      repeat (60) @(negedge clk);
      readyWord(24'h5A5A01, 1'b1);
      waitRes(rBase + 1); dout = 1'b1;
      repeat (60) @(negedge clk);
      readyWord(24'h0F0F80, 1'b1);
      waitRes(rBase + 2); dout = 1'b1;
      check(results[rBase] == 24'h5A5A01 && results[rBase+1] == 24'h0F0F80, "R7 stream results",
            results[rBase+1], 24'h0F0F80);
      check(nLog == 11 && logBytes[5] == 8'h00 && logBytes[8] == 8'h00, "R7 data-in low, no command",
            nLog, 11);
      pulseStop();
      repeat (40) @(negedge clk);
      check(busy && !csN, "R8 waits for ready before exit", {30'b0, busy, csN}, 32'h2);
      readyWord(24'hFFFFFF, 1'b0);
      devSh = '1;
      waitIdle(); dout = 1'b1;
      repeat (10) @(negedge clk);
      check(nLog == 12 && logBytes[11] == 8'h38, "R8 exit command", logBytes[11], 8'h38);
      check(nRes == rBase + 2, "R8 no result on exit", nRes, rBase + 2);
    end

    // R9 timeout
    begin
      int t0, dt, rBase;
      nLog = 0; rBase = nRes;
      timeoutLimit = 24'd300;
      opMode = 2'd0;
      pulseStart();
      waitLog(4);
      t0 = cyc;
      for (int i = 0; i < 2000 && nTo == 0; i++) @(negedge clk);
      dt = cyc - t0;
      check(nTo == 1 && dt >= 300 && dt <= 340, "R9 timeout window", dt, 300);
      check(csN && !busy && nRes == rBase, "R9 released, no result", {30'b0, csN, busy}, 32'h2);
      timeoutLimit = 24'd100000;
    end

    // R10 resync
    begin
      int n;
      nLog = 0;
      @(negedge clk) resyncReq = 1'b1;
      @(negedge clk) resyncReq = 1'b0;
      for (int i = 0; i < 4000 && !csN; i++) @(negedge clk);
      for (int i = 0; i < 4000 && !csN; i++) @(negedge clk);
      n = 0;
      while (busy && n < 1000) begin n++; @(negedge clk); end
      check(nLog == 4, "R10 thirty-two clocks", nLog, 4);
      check(logBytes[0] == 8'hFF && logBytes[1] == 8'hFF && logBytes[2] == 8'hFF &&
            logBytes[3] == 8'hFF, "R10 data-in high", {logBytes[0], logBytes[3]}, 16'hFFFF);
      check(n >= SETTLE - 1 && n <= SETTLE + 2, "R10 settle time", n, SETTLE);
    end

    finishRun();
  end
endmodule